// File: doc/BRIEF.md
# Control Endpoint Status and Packet Buffer

This block holds the status logic and the only data buffer of the bidirectional control endpoint (endpoint 0) of a USB function. A single 32-byte buffer carries either an IN packet, loaded by the CPU and drained by the packet engine, or an OUT packet, filled by the packet engine and read by the CPU. It never carries both at once. Each ready bit is set by one side and cleared by the other. The block also keeps two sticky bits: one for a STALL handshake sent by the engine, and one for a control transfer that ended early. It raises one endpoint-0 interrupt event pulse.

The block also holds the device address register and the endpoint index register. While the address is zero, the engine may exchange traffic only on endpoint 0. Writes to the control/status strobe take effect only while the index register selects endpoint 0. A state machine tracks the buffer direction. Its states are:
- `ST_IDLE`: the buffer is empty and has no direction.
- `ST_IN_LOAD`: the CPU is filling an IN packet.
- `ST_IN_ARMED`: the IN packet is ready and waits for the engine.
- `ST_OUT_RECV`: the engine is filling an OUT packet.
- `ST_OUT_HELD`: a received OUT packet waits for the CPU.

Its transitions are:
- `ST_IDLE` goes to `ST_OUT_RECV` on an engine byte.
- `ST_IDLE` goes to `ST_OUT_HELD` on an engine packet end.
- `ST_IDLE` goes to `ST_IN_LOAD` on a CPU byte.
- `ST_IDLE` goes to `ST_IN_ARMED` on the set-IN-ready command.
- `ST_IN_LOAD` goes to `ST_IN_ARMED` on the set-IN-ready command.
- `ST_IN_ARMED` goes to `ST_IDLE` on the engine's sent pulse.
- `ST_OUT_RECV` goes to `ST_OUT_HELD` on an engine packet end.
- `ST_OUT_HELD` goes to `ST_IDLE` on the clear-OUT-ready command.

Every return to `ST_IDLE` empties the buffer.

Top module: `usb_ep0_ctrl`

## Requirements
- R1: After reset the following all read 0: `in_rdy`, `out_rdy`, `stall_sent`, `setup_end`, `ovf`, `ep0_irq`, `byte_cnt` and `dev_addr`. The index register reads 0, so `ep0_sel` is 1.
- R2: `byte_cnt` gives the number of bytes held in the buffer. The buffer holds at most 32 bytes. A push into a full buffer is dropped: `byte_cnt` stays 32 and `ovf` goes to 1.
- R3: `eng_pkt_end` sets `out_rdy` in `ST_IDLE` or `ST_OUT_RECV`. `out_rdy` stays set until the CPU clears it. While it is set, `rd_data` shows the received bytes in arrival order, advancing on each `cpu_pop`.
- R4: A control/status write with bit 1 set clears `out_rdy`. The same write sets `byte_cnt` to 0, clears `ovf` and rewinds the read position.
- R5: A control/status write with bit 0 set raises `in_rdy`. The engine then reads the loaded bytes in order through `rd_data` and `eng_pop`. `eng_in_sent` then clears `in_rdy` and empties the buffer.
- R6: Only one direction is served at a time. Engine bytes are ignored from `ST_IN_LOAD` onwards until the IN packet is sent. CPU bytes are ignored from `ST_OUT_RECV` onwards until `out_rdy` is cleared. An ignored push leaves `byte_cnt` unchanged.
- R7: `eng_stall` sets `stall_sent` and `eng_setup_end` sets `setup_end`. Each bit stays set until a control/status write clears it: bit 2 clears `stall_sent` and bit 3 clears `setup_end`.
- R8: `eng_status_done` (the status stage of an IN transaction has finished) raises the interrupt event without changing any status bit.
- R9: A control/status write has an effect only while the index register is 0. `cpu_idx_we` loads the index from `cpu_wdata[3:0]`, and `ep0_sel` shows whether the index is 0.
- R10: `cpu_addr_we` loads `dev_addr` from `cpu_wdata[6:0]`; bit 7 is ignored. `ep_ok` is 1 when `eng_ep` is 0 or `dev_addr` is nonzero, and 0 otherwise.
- R11: `ep0_irq` is high for exactly one cycle, in the cycle after any clock edge that samples an event. The events are: an accepted packet end, a sent IN packet, a status-stage completion, a STALL, or a setup end. Coincident events give one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wdata | input | 8 | CPU write data for all CPU write strobes |
| cpu_addr_we | input | 1 | Load device address |
| cpu_idx_we | input | 1 | Load endpoint index |
| cpu_cs_we | input | 1 | Control/status command write (bit0 set IN ready, bit1 clear OUT ready, bit2 clear STALL, bit3 clear setup end) |
| cpu_push | input | 1 | CPU writes one IN byte from cpu_wdata |
| cpu_pop | input | 1 | CPU consumes one OUT byte |
| eng_push | input | 1 | Engine writes one received byte |
| eng_data | input | 8 | Received byte |
| eng_pkt_end | input | 1 | Engine: OUT packet complete |
| eng_pop | input | 1 | Engine consumes one IN byte |
| eng_in_sent | input | 1 | Engine: IN packet delivered |
| eng_status_done | input | 1 | Engine: status stage of IN transaction done |
| eng_stall | input | 1 | Engine: STALL handshake sent |
| eng_setup_end | input | 1 | Engine: control transfer ended early |
| eng_ep | input | 4 | Endpoint number of current token |
| rd_data | output | 8 | Buffer byte at the read position |
| byte_cnt | output | 6 | Bytes held in buffer |
| ovf | output | 1 | A push was dropped on a full buffer |
| in_rdy | output | 1 | IN packet ready |
| out_rdy | output | 1 | OUT packet received |
| stall_sent | output | 1 | Sticky STALL-sent bit |
| setup_end | output | 1 | Sticky early-end bit |
| ep0_irq | output | 1 | One-cycle interrupt event |
| ep0_sel | output | 1 | Index register is 0 |
| dev_addr | output | 7 | Device address |
| ep_ok | output | 1 | Engine may serve eng_ep |

## Verification
Every result except `rd_data` and `ep_ok` is registered. Each is due in the cycle after the clock edge that samples its stimulus; `ep0_irq` is due in that cycle only. `rd_data` and `ep_ok` follow the registered state combinationally, so they are valid in the same cycle after that edge. The bench drives every strobe on a falling edge and removes it on the next falling edge. It checks at that second falling edge, half a period after the rising edge that sampled the strobe. It then checks again one cycle later to confirm that the interrupt pulse has ended and that the sticky bits have held.

// File: rtl/usb_ep0_pkg.sv
package usb_ep0_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_IN_LOAD  = 3'd1,
        ST_IN_ARMED = 3'd2,
        ST_OUT_RECV = 3'd3,
        ST_OUT_HELD = 3'd4
    } ep0_state_e;

    localparam int CS_SET_IN    = 0;
    localparam int CS_CLR_OUT   = 1;
    localparam int CS_CLR_STALL = 2;
    localparam int CS_CLR_SETUP = 3;
endpackage

// File: rtl/usb_ep0_buf.sv
module usb_ep0_buf #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count,
    output logic              ovf
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  wr_pos;
    logic [CNT_W-1:0]  rd_pos;
    logic              full;

    assign full  = (wr_pos == CNT_W'(DEPTH));
    assign count = wr_pos;
    assign rdata = mem[rd_pos[IDX_W-1:0]];

    always_ff @(posedge clk) begin
        if (push && !full && !clr)
            mem[wr_pos[IDX_W-1:0]] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_pos <= '0;
            rd_pos <= '0;
            ovf    <= 1'b0;
        end else if (clr) begin
            wr_pos <= '0;
            rd_pos <= '0;
            ovf    <= 1'b0;
        end else begin
            if (push) begin
                if (full) ovf <= 1'b1;
                else      wr_pos <= wr_pos + 1'b1;
            end
            if (pop && (rd_pos < wr_pos))
                rd_pos <= rd_pos + 1'b1;
        end
    end

    // R2: occupancy never exceeds the buffer size
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R2: a push on a full buffer is dropped and flagged
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr && count == CNT_W'(DEPTH)) |=> (count == CNT_W'(DEPTH) && ovf));
endmodule

// File: rtl/usb_ep0_fsm.sv
module usb_ep0_fsm
    import usb_ep0_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_push,
    input  logic cpu_pop,
    input  logic cs_set_in,
    input  logic cs_clr_out,
    input  logic cs_clr_stall,
    input  logic cs_clr_setup,
    input  logic eng_push,
    input  logic eng_pkt_end,
    input  logic eng_pop,
    input  logic eng_in_sent,
    input  logic eng_status_done,
    input  logic eng_stall,
    input  logic eng_setup_end,
    output logic buf_push,
    output logic buf_sel_eng,
    output logic buf_pop,
    output logic buf_clr,
    output logic in_rdy,
    output logic out_rdy,
    output logic stall_sent,
    output logic setup_end,
    output logic ep0_irq
);
    ep0_state_e state, state_nx;
    logic       done_ok, sent_ok, evt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (eng_pkt_end)   state_nx = ST_OUT_HELD;
                else if (eng_push) state_nx = ST_OUT_RECV;
                else if (cs_set_in) state_nx = ST_IN_ARMED;
                else if (cpu_push) state_nx = ST_IN_LOAD;
            end
            ST_IN_LOAD:  if (cs_set_in)   state_nx = ST_IN_ARMED;
            ST_IN_ARMED: if (eng_in_sent) state_nx = ST_IDLE;
            ST_OUT_RECV: if (eng_pkt_end) state_nx = ST_OUT_HELD;
            ST_OUT_HELD: if (cs_clr_out)  state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // outputs and buffer control
    always_comb begin
        buf_push    = 1'b0;
        buf_sel_eng = 1'b0;
        buf_pop     = 1'b0;
        done_ok     = 1'b0;
        sent_ok     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                buf_sel_eng = eng_push;
                buf_push    = eng_push || cpu_push;
                done_ok     = eng_pkt_end;
            end
            ST_IN_LOAD:  buf_push = cpu_push;
            ST_IN_ARMED: begin
                buf_pop = eng_pop;
                sent_ok = eng_in_sent;
            end
            ST_OUT_RECV: begin
                buf_sel_eng = 1'b1;
                buf_push    = eng_push;
                done_ok     = eng_pkt_end;
            end
            ST_OUT_HELD: buf_pop = cpu_pop;
            default: ;
        endcase
        buf_clr = sent_ok || (state == ST_OUT_HELD && cs_clr_out);
        in_rdy  = (state == ST_IN_ARMED);
        out_rdy = (state == ST_OUT_HELD);
    end

    assign evt = done_ok || sent_ok || eng_status_done || eng_stall || eng_setup_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stall_sent <= 1'b0;
            setup_end  <= 1'b0;
            ep0_irq    <= 1'b0;
        end else begin
            ep0_irq <= evt;
            if (eng_stall)          stall_sent <= 1'b1;
            else if (cs_clr_stall)  stall_sent <= 1'b0;
            if (eng_setup_end)      setup_end  <= 1'b1;
            else if (cs_clr_setup)  setup_end  <= 1'b0;
        end
    end

    // R5: a sent pulse while armed drops IN ready and raises the event
    a_r5_sent_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rdy && eng_in_sent) |=> (!in_rdy && ep0_irq));

    // R3: OUT ready holds until the CPU clears it
    a_r3_out_held: assert property (@(posedge clk) disable iff (!rst_n)
        (out_rdy && !cs_clr_out) |=> out_rdy);

    // R7: STALL-sent bit is sticky until cleared
    a_r7_stall_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_sent && !cs_clr_stall) |=> stall_sent);

    // R11: every STALL or setup-end event produces the interrupt pulse
    a_r11_irq_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_stall || eng_setup_end) |=> ep0_irq);

    // R6: directions never overlap
    a_r6_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_rdy && out_rdy));
endmodule

// File: rtl/usb_ep0_ctrl.sv
module usb_ep0_ctrl
    import usb_ep0_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 32,
    parameter int ADDR_W  = 7,
    parameter int EPIDX_W = 4,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic               cpu_addr_we,
    input  logic               cpu_idx_we,
    input  logic               cpu_cs_we,
    input  logic               cpu_push,
    input  logic               cpu_pop,
    input  logic               eng_push,
    input  logic [DATA_W-1:0]  eng_data,
    input  logic               eng_pkt_end,
    input  logic               eng_pop,
    input  logic               eng_in_sent,
    input  logic               eng_status_done,
    input  logic               eng_stall,
    input  logic               eng_setup_end,
    input  logic [EPIDX_W-1:0] eng_ep,
    output logic [DATA_W-1:0]  rd_data,
    output logic [CNT_W-1:0]   byte_cnt,
    output logic               ovf,
    output logic               in_rdy,
    output logic               out_rdy,
    output logic               stall_sent,
    output logic               setup_end,
    output logic               ep0_irq,
    output logic               ep0_sel,
    output logic [ADDR_W-1:0]  dev_addr,
    output logic               ep_ok
);
    logic [EPIDX_W-1:0] ep_idx;
    logic               cs_en;
    logic               buf_push, buf_sel_eng, buf_pop, buf_clr;
    logic [DATA_W-1:0]  buf_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_addr <= '0;
            ep_idx   <= '0;
        end else begin
            if (cpu_addr_we) dev_addr <= cpu_wdata[ADDR_W-1:0];
            if (cpu_idx_we)  ep_idx   <= cpu_wdata[EPIDX_W-1:0];
        end
    end

    assign ep0_sel   = (ep_idx == '0);
    assign cs_en     = cpu_cs_we && ep0_sel;
    assign ep_ok     = (eng_ep == '0) || (dev_addr != '0);
    assign buf_wdata = buf_sel_eng ? eng_data : cpu_wdata;

    usb_ep0_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .cpu_push        (cpu_push),
        .cpu_pop         (cpu_pop),
        .cs_set_in       (cs_en && cpu_wdata[CS_SET_IN]),
        .cs_clr_out      (cs_en && cpu_wdata[CS_CLR_OUT]),
        .cs_clr_stall    (cs_en && cpu_wdata[CS_CLR_STALL]),
        .cs_clr_setup    (cs_en && cpu_wdata[CS_CLR_SETUP]),
        .eng_push        (eng_push),
        .eng_pkt_end     (eng_pkt_end),
        .eng_pop         (eng_pop),
        .eng_in_sent     (eng_in_sent),
        .eng_status_done (eng_status_done),
        .eng_stall       (eng_stall),
        .eng_setup_end   (eng_setup_end),
        .buf_push        (buf_push),
        .buf_sel_eng     (buf_sel_eng),
        .buf_pop         (buf_pop),
        .buf_clr         (buf_clr),
        .in_rdy          (in_rdy),
        .out_rdy         (out_rdy),
        .stall_sent      (stall_sent),
        .setup_end       (setup_end),
        .ep0_irq         (ep0_irq)
    );

    usb_ep0_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (buf_clr),
        .push  (buf_push),
        .wdata (buf_wdata),
        .pop   (buf_pop),
        .rdata (rd_data),
        .count (byte_cnt),
        .ovf   (ovf)
    );

    // R10: an address write lands in the device address register
    a_r10_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr_we |=> (dev_addr == $past(cpu_wdata[ADDR_W-1:0])));

    // R9: a command write with a nonzero index leaves the sticky bits untouched
    a_r9_idx_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_cs_we && !ep0_sel && !eng_stall && !eng_setup_end)
            |=> (stall_sent == $past(stall_sent) && setup_end == $past(setup_end)));
endmodule

// File: tb/usb_ep0_ctrl_tb.sv
module usb_ep0_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic       cpu_addr_we = 0, cpu_idx_we = 0, cpu_cs_we = 0, cpu_push = 0, cpu_pop = 0;
    logic       eng_push = 0, eng_pkt_end = 0, eng_pop = 0, eng_in_sent = 0;
    logic       eng_status_done = 0, eng_stall = 0, eng_setup_end = 0;
    logic [7:0] eng_data = '0;
    logic [3:0] eng_ep = '0;
    logic [7:0] rd_data;
    logic [5:0] byte_cnt;
    logic       ovf, in_rdy, out_rdy, stall_sent, setup_end, ep0_irq, ep0_sel, ep_ok;
    logic [6:0] dev_addr;

    int n_chk = 0, n_fail = 0, cyc_n = 0;

    always #4 clk = ~clk;

    usb_ep0_ctrl u_dut (.*);

    // R10 vectors: {written address byte, token endpoint, expected ep_ok}
    localparam logic [12:0] ADDR_VEC [6] = '{
        {8'h00, 4'd0,  1'b1},
        {8'h00, 4'd3,  1'b0},
        {8'h05, 4'd3,  1'b1},
        {8'hFF, 4'd15, 1'b1},
        {8'h80, 4'd15, 1'b0},
        {8'h01, 4'd1,  1'b1}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cpu_addr_we = 0; cpu_idx_we = 0; cpu_cs_we = 0; cpu_push = 0; cpu_pop = 0;
        eng_push = 0; eng_pkt_end = 0; eng_pop = 0; eng_in_sent = 0;
        eng_status_done = 0; eng_stall = 0; eng_setup_end = 0;
    endtask

    task automatic cs_write(input logic [7:0] v);
        cpu_cs_we = 1; cpu_wdata = v; step();
    endtask

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc_n, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset state
        check("R1 in_rdy", in_rdy, 0);
        check("R1 out_rdy", out_rdy, 0);
        check("R1 byte_cnt", byte_cnt, 0);
        check("R1 dev_addr", dev_addr, 0);
        check("R1 irq", ep0_irq, 0);
        check("R1 ep0_sel", ep0_sel, 1);
        check("R1 flags", {stall_sent, setup_end, ovf}, 0);
        rst_n = 1'b1;
        step();

        // R10 table walk
        foreach (ADDR_VEC[i]) begin
            cpu_addr_we = 1; cpu_wdata = ADDR_VEC[i][12:5]; eng_ep = ADDR_VEC[i][4:1];
            step();
            check("R10 dev_addr", dev_addr, int'(ADDR_VEC[i][11:5]));
            check("R10 ep_ok", ep_ok, int'(ADDR_VEC[i][0]));
        end

        // OUT packet of 5 bytes (R2, R3)
        for (int i = 0; i < 5; i++) begin
            eng_push = 1; eng_data = 8'hA0 + 8'(i); step();
        end
        check("R2 count", byte_cnt, 5);
        check("R3 not ready yet", out_rdy, 0);
        eng_pkt_end = 1; step();
        check("R3 out_rdy", out_rdy, 1);
        check("R11 irq on packet end", ep0_irq, 1);
        step();
        check("R11 irq one cycle", ep0_irq, 0);
        // R6 wrong-direction pushes ignored
        cpu_push = 1; cpu_wdata = 8'h55; step();
        check("R6 cpu push ignored", byte_cnt, 5);
        eng_push = 1; eng_data = 8'h66; step();
        check("R6 eng push ignored", byte_cnt, 5);
        for (int i = 0; i < 5; i++) begin
            check("R3 rd_data order", rd_data, 8'hA0 + i);
            cpu_pop = 1; step();
        end
        // R9 clear with nonzero index has no effect
        cpu_idx_we = 1; cpu_wdata = 8'h02; step();
        check("R9 ep0_sel low", ep0_sel, 0);
        cs_write(8'h02);
        check("R9 gated clear", out_rdy, 1);
        cpu_idx_we = 1; cpu_wdata = 8'h00; step();
        cs_write(8'h02);
        check("R4 out_rdy cleared", out_rdy, 0);
        check("R4 count cleared", byte_cnt, 0);

        // R2 overflow on 33rd byte
        for (int i = 0; i < 33; i++) begin
            eng_push = 1; eng_data = 8'(i); step();
        end
        check("R2 count capped", byte_cnt, 32);
        check("R2 ovf", ovf, 1);
        eng_pkt_end = 1; step();
        check("R3 first byte kept", rd_data, 0);
        cs_write(8'h02);
        check("R4 ovf cleared", ovf, 0);
        check("R4 count zero", byte_cnt, 0);

        // IN packet (R5, R6)
        for (int i = 0; i < 3; i++) begin
            cpu_push = 1; cpu_wdata = 8'h10 + 8'(i); step();
        end
        check("R5 loaded count", byte_cnt, 3);
        eng_push = 1; eng_data = 8'h77; step();
        check("R6 eng push during load", byte_cnt, 3);
        cs_write(8'h01);
        check("R5 in_rdy", in_rdy, 1);
        check("R11 no irq on arm", ep0_irq, 0);
        for (int i = 0; i < 3; i++) begin
            check("R5 rd_data order", rd_data, 8'h10 + i);
            eng_pop = 1; step();
        end
        eng_in_sent = 1; step();
        check("R5 in_rdy cleared", in_rdy, 0);
        check("R5 irq on sent", ep0_irq, 1);
        check("R5 buffer emptied", byte_cnt, 0);

        // R7 stall sticky, R9 gating
        eng_stall = 1; step();
        check("R7 stall set", stall_sent, 1);
        check("R11 irq on stall", ep0_irq, 1);
        step(); step();
        check("R7 stall holds", stall_sent, 1);
        cpu_idx_we = 1; cpu_wdata = 8'h03; step();
        cs_write(8'h04);
        check("R9 stall kept", stall_sent, 1);
        cpu_idx_we = 1; cpu_wdata = 8'h00; step();
        cs_write(8'h04);
        check("R7 stall cleared", stall_sent, 0);
        eng_setup_end = 1; step();
        check("R7 setup_end set", setup_end, 1);
        cs_write(8'h04);
        check("R7 setup_end independent", setup_end, 1);
        cs_write(8'h08);
        check("R7 setup_end cleared", setup_end, 0);

        // R8 status stage
        eng_status_done = 1; step();
        check("R8 irq", ep0_irq, 1);
        check("R8 flags unchanged", {in_rdy, out_rdy, stall_sent, setup_end}, 0);

        // R11 coincident events: one pulse
        eng_stall = 1; eng_setup_end = 1; eng_status_done = 1; step();
        check("R11 coincident pulse", ep0_irq, 1);
        step();
        check("R11 pulse ended", ep0_irq, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule